// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Subtract Unit

This block computes one half-precision (binary16) fused multiply-subtract per accepted request. It takes three 16-bit operands, a two-bit form code that picks which operand is the subtrahend and which two are multiplied, a negate bit that flips the sign of the product, and a two-bit rounding-direction code. The exact product keeps every bit of precision. Only the final difference is rounded, and it is rounded once.

Internally the product and the subtrahend are placed on one wide fixed-point grid. That grid covers every binary16 magnitude exactly, so the signed sum carries no error before normalisation and rounding. Infinities, zeros, subnormals and NaNs are handled in a separate special-case path. Each result comes out one clock after its request, together with five exception flags. The flags describe that result alone and are not accumulated.

Top module: `fp16_fms_unit`

## Requirements
- R1: `form` picks the operands as A×B−C. Code 00 gives A=op1, B=op3, C=op2. Code 01 gives A=op2, B=op1, C=op3. Code 10 gives A=op2, B=op3, C=op1. Code 11 behaves exactly like 00.
- R2: With `neg`=1 the exact product is negated before C is subtracted, so the result is −(A×B)−C.
- R3: The exact difference A×B−C is rounded only once. The product is never rounded on its own.
- R4: `rmode` selects the rounding direction: 00 nearest-even, 01 toward −∞, 10 toward +∞, 11 toward zero.
- R5: An exact zero result built from two zero terms of equal sign keeps that sign. Every other exact zero is +0, except under toward −∞, where it is −0.
- R6: A rounded magnitude above 0x7BFF gives ±infinity under nearest-even and under the direction that points away from zero. Otherwise it gives ±0x7BFF. In both cases it raises overflow and inexact.
- R7: Results below the smallest normal are returned as subnormals. Underflow is raised only when such a result, judged before rounding, is also inexact.
- R8: Any NaN operand returns 0x7E00. Invalid is raised when a signalling NaN (exponent all ones, fraction nonzero, fraction bit 9 clear) is present, and not for quiet NaNs.
- R9: Infinity times zero, and infinity minus an infinity of the same effective sign, return 0x7E00 with invalid set. Other infinite cases return the correctly signed infinity with no flags.
- R10: `flg_denorm` is set whenever any of the three operands is subnormal.
- R11: Each request with `in_valid` high gives `out_valid` high with its result on the next cycle. With no request, `out_valid` is low and the result and flags hold. Reset clears all outputs.
- R12: `flg_inexact` is set whenever the delivered finite result differs from the exact value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op1 | input | 16 | Operand 1 (binary16) |
| op2 | input | 16 | Operand 2 (binary16) |
| op3 | input | 16 | Operand 3 (binary16) |
| form | input | 2 | Operand ordering code |
| neg | input | 1 | Negate the product |
| rmode | input | 2 | Rounding direction code |
| out_valid | output | 1 | Result strobe, one cycle after request |
| result | output | 16 | Rounded binary16 result |
| flg_invalid | output | 1 | Invalid operation |
| flg_denorm | output | 1 | Subnormal operand seen |
| flg_overflow | output | 1 | Overflow |
| flg_underflow | output | 1 | Tiny and inexact |
| flg_inexact | output | 1 | Rounded result is not exact |

## Verification
The checker assumes that operands, codes and `in_valid` are known (not X) on every sampled edge after reset, and that `in_valid` is low while reset is held. The bench drives inputs only at falling edges and holds `in_valid` low throughout reset. It issues requests separated by idle cycles, so the hold properties are exercised between results. Every operand pattern is a fully specified 16-bit code, covering ties, cancellation, overflow, subnormals, infinities and both NaN kinds.

// File: rtl/fp16_fms_unit.sv
module fp16_fms_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] op1,
  input  logic [15:0] op2,
  input  logic [15:0] op3,
  input  logic [1:0]  form,
  input  logic        neg,
  input  logic [1:0]  rmode,
  output logic        out_valid,
  output logic [15:0] result,
  output logic        flg_invalid,
  output logic        flg_denorm,
  output logic        flg_overflow,
  output logic        flg_underflow,
  output logic        flg_inexact
);
  localparam int SW = 82;
  localparam logic [15:0] QNAN = 16'h7E00;
  localparam logic [6:0] MIN_NORM_POS = 7'd34;
  localparam logic [6:0] SUB_LSB_POS = 7'd24;

  function automatic logic is_nan(input logic [15:0] x);
    return x[14:10] == 5'h1F && x[9:0] != 10'd0;
  endfunction
  function automatic logic is_inf(input logic [15:0] x);
    return x[14:10] == 5'h1F && x[9:0] == 10'd0;
  endfunction
  function automatic logic is_zero(input logic [15:0] x);
    return x[14:0] == 15'd0;
  endfunction
  function automatic logic is_sub(input logic [15:0] x);
    return x[14:10] == 5'd0 && x[9:0] != 10'd0;
  endfunction
  function automatic logic [10:0] sig(input logic [15:0] x);
    return {x[14:10] != 5'd0, x[9:0]};
  endfunction
  function automatic logic [6:0] bexp(input logic [15:0] x);
    return (x[14:10] == 5'd0) ? 7'd1 : {2'b0, x[14:10]};
  endfunction

  logic [15:0] a, b, c;
  always_comb begin
    unique case (form)
      2'd1:    {a, b, c} = {op2, op1, op3};
      2'd2:    {a, b, c} = {op2, op3, op1};
      default: {a, b, c} = {op1, op3, op2};
    endcase
  end

  // exact alignment on a grid whose LSB weighs 2^-48
  logic sp, sc;
  logic [21:0] prod;
  logic [6:0] pshift, cshift;
  logic [SW-1:0] pmag, cmag, mag;
  logic signed [SW:0] pterm, cterm, sum;
  logic rsign;

  assign sp     = a[15] ^ b[15] ^ neg;
  assign sc     = ~c[15];
  assign prod   = sig(a) * sig(b);
  assign pshift = bexp(a) + bexp(b) - 7'd2;
  assign cshift = bexp(c) + 7'd23;
  assign pmag   = SW'(prod) << pshift;
  assign cmag   = SW'(sig(c)) << cshift;
  assign pterm  = sp ? -$signed({1'b0, pmag}) : $signed({1'b0, pmag});
  assign cterm  = sc ? -$signed({1'b0, cmag}) : $signed({1'b0, cmag});
  assign sum    = pterm + cterm;
  assign rsign  = sum[SW];
  assign mag    = rsign ? SW'(-sum) : SW'(sum);

  logic [6:0] msb;
  always_comb begin
    msb = 7'd0;
    for (int i = 0; i < SW; i++)
      if (mag[i]) msb = 7'(i);
  end

  logic tiny, inc, inexact_f, ovf, ovf_inf;
  logic [6:0] lsbpos;
  logic [SW-1:0] kept_w, rem, half;
  logic [11:0] rnd;
  logic [16:0] base, packed_v;

  assign tiny      = msb < MIN_NORM_POS;
  assign lsbpos    = tiny ? SUB_LSB_POS : msb - 7'd10;
  assign kept_w    = mag >> lsbpos;
  assign rem       = mag & ((SW'(1) << lsbpos) - SW'(1));
  assign half      = SW'(1) << (lsbpos - 7'd1);
  assign inexact_f = rem != '0;

  always_comb begin
    unique case (rmode)
      2'd0:    inc = (rem > half) || (rem == half && kept_w[0]);
      2'd1:    inc = inexact_f && rsign;
      2'd2:    inc = inexact_f && !rsign;
      default: inc = 1'b0;
    endcase
  end

  assign rnd      = {1'b0, kept_w[10:0]} + 12'(inc);
  assign base     = tiny ? 17'd0 : (17'(msb) - 17'(MIN_NORM_POS)) << 10;
  assign packed_v = base + {5'd0, rnd};
  assign ovf      = packed_v >= 17'h7C00;
  assign ovf_inf  = rmode == 2'd0 || (rmode == 2'd1 && rsign) || (rmode == 2'd2 && !rsign);

  logic nan_in, snan_in, inf_zero, pinf, cinf, inf_cancel, zsign, den_in;
  assign nan_in     = is_nan(a) || is_nan(b) || is_nan(c);
  assign snan_in    = (is_nan(a) && !a[9]) || (is_nan(b) && !b[9]) || (is_nan(c) && !c[9]);
  assign inf_zero   = (is_inf(a) && is_zero(b)) || (is_zero(a) && is_inf(b));
  assign pinf       = is_inf(a) || is_inf(b);
  assign cinf       = is_inf(c);
  assign inf_cancel = pinf && cinf && (sp != sc);
  assign zsign      = ((is_zero(a) || is_zero(b)) && is_zero(c) && sp == sc) ? sp : (rmode == 2'd1);
  assign den_in     = is_sub(op1) || is_sub(op2) || is_sub(op3);

  logic [15:0] n_res;
  logic n_inv, n_ovf, n_unf, n_inx;
  always_comb begin
    n_inv = snan_in || inf_zero || inf_cancel;
    n_ovf = 1'b0;
    n_unf = 1'b0;
    n_inx = 1'b0;
    if (nan_in || inf_zero || inf_cancel) n_res = QNAN;
    else if (pinf)                        n_res = {sp, 15'h7C00};
    else if (cinf)                        n_res = {sc, 15'h7C00};
    else if (mag == '0)                   n_res = {zsign, 15'h0000};
    else if (ovf) begin
      n_res = {rsign, ovf_inf ? 15'h7C00 : 15'h7BFF};
      n_ovf = 1'b1;
      n_inx = 1'b1;
    end else begin
      n_res = {rsign, packed_v[14:0]};
      n_unf = tiny && inexact_f;
      n_inx = inexact_f;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 16'h0000;
      {flg_invalid, flg_denorm, flg_overflow, flg_underflow, flg_inexact} <= 5'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= n_res;
        {flg_invalid, flg_denorm, flg_overflow, flg_underflow, flg_inexact} <=
          {n_inv, den_in, n_ovf, n_unf, n_inx};
      end
    end
  end
endmodule

module fp16_fms_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [15:0] result,
  input logic        flg_invalid,
  input logic        flg_overflow,
  input logic        flg_underflow,
  input logic        flg_inexact
);
  // R11
  req_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R11
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result));
  // R8
  nan_canonical_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[14:10] == 5'h1F && result[9:0] != 10'd0) |-> result == 16'h7E00);
  // R9
  invalid_gives_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flg_invalid) |-> result == 16'h7E00);
  // R6
  overflow_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_overflow |-> (flg_inexact && (result[14:0] == 15'h7C00 || result[14:0] == 15'h7BFF)));
  // R7
  underflow_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_underflow |-> (flg_inexact && result[14:10] <= 5'd1));
endmodule

bind fp16_fms_unit fp16_fms_unit_chk chk_i (.*);

// File: tb/fp16_fms_unit_tb_top.sv
`timescale 1ns/1ps
module fp16_fms_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] op1 = '0, op2 = '0, op3 = '0;
  logic [1:0] form = '0, rmode = '0;
  logic neg = 1'b0;
  logic out_valid;
  logic [15:0] result;
  logic flg_invalid, flg_denorm, flg_overflow, flg_underflow, flg_inexact;

  always #4 clk = ~clk;

  fp16_fms_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op1(op1), .op2(op2), .op3(op3), .form(form), .neg(neg), .rmode(rmode),
    .out_valid(out_valid), .result(result),
    .flg_invalid(flg_invalid), .flg_denorm(flg_denorm), .flg_overflow(flg_overflow),
    .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
  );

  localparam logic [4:0] F_NONE = 5'b00000, F_INV = 5'b10000, F_DEN = 5'b01000,
                         F_OVF = 5'b00100, F_UNF = 5'b00010, F_INX = 5'b00001;

  typedef struct {
    logic [15:0] res;
    logic [4:0]  flg;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(input logic [15:0] a1, input logic [15:0] a2, input logic [15:0] a3,
                       input logic [1:0] f, input logic n, input logic [1:0] rm,
                       input logic [15:0] er, input logic [4:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    op1 = a1; op2 = a2; op3 = a3; form = f; neg = n; rmode = rm; in_valid = 1'b1;
    e.res = er; e.flg = ef; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        check("R11 unexpected out_valid", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " result"}, 32'(result), 32'(e.res));
        check({e.tag, " flags"},
              32'({flg_invalid, flg_denorm, flg_overflow, flg_underflow, flg_inexact}), 32'(e.flg));
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog expired with %0d pending", sb_q.size());
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", 32'(out_valid), 32'd0);
    check("R11 reset result", 32'(result), 32'd0);
    rst_n = 1'b1;

    // R1 operand ordering forms
    issue(16'h4200, 16'h4000, 16'h4400, 2'd0, 1'b0, 2'd0, 16'h4900, F_NONE, "R1 form00");
    issue(16'h4200, 16'h4000, 16'h4400, 2'd1, 1'b0, 2'd0, 16'h4000, F_NONE, "R1 form01");
    issue(16'h4200, 16'h4000, 16'h4400, 2'd2, 1'b0, 2'd0, 16'h4500, F_NONE, "R1 form10");
    issue(16'h4200, 16'h4000, 16'h4400, 2'd3, 1'b0, 2'd0, 16'h4900, F_NONE, "R1 form11");
    // R2 negated product
    issue(16'h4200, 16'h4000, 16'h4400, 2'd2, 1'b1, 2'd0, 16'hC980, F_NONE, "R2 neg form10");
    // R4 rounding directions, R12 inexact
    issue(16'h3C01, 16'h0000, 16'h3C01, 2'd0, 1'b0, 2'd0, 16'h3C02, F_INX, "R4 R12 rne");
    issue(16'h3C01, 16'h0000, 16'h3C01, 2'd0, 1'b0, 2'd2, 16'h3C03, F_INX, "R4 up");
    issue(16'h3C01, 16'h0000, 16'h3C01, 2'd0, 1'b0, 2'd3, 16'h3C02, F_INX, "R4 rz");
    issue(16'h3C01, 16'h0000, 16'h3C01, 2'd0, 1'b1, 2'd1, 16'hBC03, F_INX, "R4 neg down");
    issue(16'h3C01, 16'h0000, 16'h3C01, 2'd0, 1'b1, 2'd2, 16'hBC02, F_INX, "R4 neg up");
    // R3 single rounding: tie only visible with the exact product
    issue(16'h3C01, 16'h3C00, 16'h3C01, 2'd0, 1'b0, 2'd0, 16'h1800, F_INX, "R3 fused tie");
    issue(16'h3C01, 16'h3C00, 16'h3C01, 2'd0, 1'b0, 2'd2, 16'h1801, F_INX, "R3 fused up");
    // R5 zero signs
    issue(16'h3C00, 16'h3C00, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'h0000, F_NONE, "R5 cancel rne");
    issue(16'h3C00, 16'h3C00, 16'h3C00, 2'd0, 1'b0, 2'd1, 16'h8000, F_NONE, "R5 cancel down");
    issue(16'h0000, 16'h0000, 16'h0000, 2'd0, 1'b0, 2'd1, 16'h8000, F_NONE, "R5 p0-p0 down");
    issue(16'h0000, 16'h8000, 16'h0000, 2'd0, 1'b0, 2'd1, 16'h0000, F_NONE, "R5 p0-n0 down");
    issue(16'h8000, 16'h0000, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h8000, F_NONE, "R5 n0-p0 rne");
    // R6 overflow
    issue(16'h7BFF, 16'h0000, 16'h4000, 2'd0, 1'b0, 2'd0, 16'h7C00, F_OVF | F_INX, "R6 rne");
    issue(16'h7BFF, 16'h0000, 16'h4000, 2'd0, 1'b0, 2'd3, 16'h7BFF, F_OVF | F_INX, "R6 rz");
    issue(16'h7BFF, 16'h0000, 16'h4000, 2'd0, 1'b1, 2'd2, 16'hFBFF, F_OVF | F_INX, "R6 neg up");
    issue(16'h7BFF, 16'h0000, 16'h4000, 2'd0, 1'b1, 2'd1, 16'hFC00, F_OVF | F_INX, "R6 neg down");
    // R7 subnormal results
    issue(16'h0400, 16'h0000, 16'h3800, 2'd0, 1'b0, 2'd0, 16'h0200, F_NONE, "R7 exact sub");
    issue(16'h0401, 16'h0000, 16'h3800, 2'd0, 1'b0, 2'd0, 16'h0200, F_UNF | F_INX, "R7 tie sub");
    issue(16'h0401, 16'h0000, 16'h3800, 2'd0, 1'b0, 2'd2, 16'h0201, F_UNF | F_INX, "R7 up sub");
    // R10 denormal inputs
    issue(16'h0001, 16'h0000, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'h0001, F_DEN, "R10 sub op1");
    issue(16'h3C00, 16'h0001, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'h3C00, F_DEN | F_INX, "R10 R12 rne");
    issue(16'h3C00, 16'h0001, 16'h3C00, 2'd0, 1'b0, 2'd3, 16'h3BFF, F_DEN | F_INX, "R10 rz");
    // R8 NaNs
    issue(16'h3C00, 16'h7C01, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'h7E00, F_INV, "R8 snan");
    issue(16'h7E00, 16'h0000, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'h7E00, F_NONE, "R8 qnan");
    // R9 infinities
    issue(16'h7C00, 16'h3C00, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h7E00, F_INV, "R9 inf*0");
    issue(16'h7C00, 16'h7C00, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'h7E00, F_INV, "R9 inf-inf");
    issue(16'h7C00, 16'hFC00, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'h7C00, F_NONE, "R9 inf+inf");
    issue(16'h3C00, 16'h7C00, 16'h3C00, 2'd0, 1'b0, 2'd0, 16'hFC00, F_NONE, "R9 fin-inf");

    repeat (3) @(negedge clk);
    held = result;
    check("R11 idle out_valid", 32'(out_valid), 32'd0);
    repeat (4) @(negedge clk);
    check("R11 idle hold", 32'(result), 32'(held));
    check("R11 queue drained", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule